// File: doc/BRIEF.md
# Paged Register Access Slave over SPI

This block is an SPI slave that opens a byte-wide window onto a paged register space. Each chip-select frame begins with a command byte and a register-address byte. The block keeps a current page, answers a small set of local addresses itself, and forwards every other access to a request/acknowledge back port together with the current page.

Reads of ordinary registers take several frames. The frame that carries the read command launches the back-side fetch. The master then polls a status byte until the read-acknowledge flag is set. After that it pulls the fetched value out one byte per frame through a data port, least significant byte first.

Writes take one frame. The value bytes follow the address byte directly, least significant byte first. The block hands them to the back port once chip select is released.

Top module: `spi_page_slave`

## Requirements
- R1: SPI mode 0 with active-low chip select. MOSI is sampled on the rising SCLK edge and MISO changes on the falling edge, MSB first. Raising chip select restarts the bit and byte counters, and MISO is 0 while chip select is high.
- R2: Command 0x60 selects a read and 0x61 selects a write. Each is followed by an 8-bit address. Any other command byte is ignored and causes no back-side access and no page change.
- R3: A write to address 0xFF loads the byte after the address into the page register, which resets to 0. The page is sent on `bk_page` with every later back access, and a read of 0xFF returns it.
- R4: A read command to an address other than 0xF0, 0xFE or 0xFF raises `bk_req` with `bk_we`=0, the current page and the address. The request is held stable until `bk_ack`.
- R5: A read of 0xFE returns the status byte in the third byte of the same frame. Bit 5 is read-acknowledge. Bit 7 is 1 when no back access is outstanding. All other bits are 0.
- R6: Read-acknowledge is set in the cycle after `bk_ack` of a read. Successive reads of 0xF0, one per frame and each in the third byte period, return the 8 fetched bytes least significant first.
- R7: Read-acknowledge clears after the 8th byte is read from 0xF0 or when a new read command arrives. A read of 0xF0 while the flag is clear returns 0x00.
- R8: In a write frame, the bytes after the address are packed least significant first into `bk_wdata`, up to 8 of them. Bytes beyond 8 are dropped. When chip select rises, a write request is issued with `bk_wbytes` set to the count.
- R9: Reads of 0xF0, 0xFE and 0xFF never start a back access. Writes to 0xF0 and 0xFE change nothing.
- R10: After reset `bk_req` is 0, MISO is 0, the page is 0 and read-acknowledge is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | SPI clock from master |
| spi_mosi | input | 1 | Master-to-slave data |
| spi_miso | output | 1 | Slave-to-master data |
| bk_req | output | 1 | Back-side request, held until acknowledged |
| bk_we | output | 1 | 1 = write request, 0 = read request |
| bk_page | output | 8 | Page of the request |
| bk_addr | output | 8 | Register address of the request |
| bk_wdata | output | 64 | Write value, byte 0 in bits 7:0 |
| bk_wbytes | output | 4 | Number of valid write bytes |
| bk_ack | input | 1 | Back-side acknowledge, one cycle |
| bk_rdata | input | 64 | Read value, valid with bk_ack |

## Verification
On every cycle, the in-line properties hold the back request stable until it is acknowledged. They require that local addresses never raise a request and that the write byte count stays within 8. They also tie every rise of read-acknowledge to a fetch and every fall to the last pop or a new read command.

The bench scenarios are needed for the end-to-end behaviour. These are the byte order seen at MISO, the status byte contents at each phase, the page reaching the back port, the packing and truncation of write bytes, and the fact that unknown commands and writes to local addresses leave no trace.

// File: rtl/spi_pg_pkg.sv
package spi_pg_pkg;
  localparam logic [7:0] OP_READ   = 8'h60;
  localparam logic [7:0] OP_WRITE  = 8'h61;
  localparam logic [7:0] ADR_PAGE  = 8'hFF;
  localparam logic [7:0] ADR_STAT  = 8'hFE;
  localparam logic [7:0] ADR_DPORT = 8'hF0;
  localparam int STAT_RACK_BIT = 5;
  localparam int STAT_IDLE_BIT = 7;

  function automatic logic [7:0] stat_byte(input logic idle, input logic rack);
    logic [7:0] s;
    s = 8'h00;
    s[STAT_IDLE_BIT] = idle;
    s[STAT_RACK_BIT] = rack;
    return s;
  endfunction

  function automatic logic is_local(input logic [7:0] a);
    return (a == ADR_PAGE) || (a == ADR_STAT) || (a == ADR_DPORT);
  endfunction
endpackage

// File: rtl/spi_pg_shift.sv
module spi_pg_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       frame_end
);
  logic [2:0] s_sclk, s_cs;
  logic [1:0] s_mosi;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh;
  logic       sclk_rise, sclk_fall, cs_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_sclk <= 3'b000;
      s_cs   <= 3'b111;
      s_mosi <= 2'b00;
    end else begin
      s_sclk <= {s_sclk[1:0], sclk};
      s_cs   <= {s_cs[1:0], cs_n};
      s_mosi <= {s_mosi[0], mosi};
    end
  end

  assign sclk_rise = s_sclk[1] & ~s_sclk[2];
  assign sclk_fall = ~s_sclk[1] & s_sclk[2];
  assign cs_act    = ~s_cs[1];
  assign frame_end = s_cs[1] & ~s_cs[2];

  always_ff @(posedge clk) begin
    if (!rst_n || !cs_act) begin
      bit_cnt   <= 3'd0;
      rx_sh     <= 8'h00;
      tx_sh     <= 8'h00;
      byte_done <= 1'b0;
    end else begin
      byte_done <= sclk_rise && (bit_cnt == 3'd7);
      if (sclk_rise) begin
        rx_sh   <= {rx_sh[6:0], s_mosi[1]};
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done)
        tx_sh <= tx_byte;
      else if (sclk_fall && bit_cnt != 3'd0)
        tx_sh <= {tx_sh[6:0], 1'b0};
    end
  end

  assign rx_byte = rx_sh;
  assign miso    = cs_act & tx_sh[7];

  assert_byte_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(sclk_rise));
  assert_idle_miso_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs[1] |-> !miso);
endmodule

// File: rtl/spi_pg_stage.sv
module spi_pg_stage #(
  parameter int NBYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [8*NBYTES-1:0] load_data,
  input  logic              pop,
  input  logic              clr,
  output logic              rack,
  output logic [7:0]        pop_byte
);
  localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [PW-1:0] LAST = PW'(NBYTES - 1);

  logic [8*NBYTES-1:0] data;
  logic [PW-1:0]       ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      ptr  <= '0;
      rack <= 1'b0;
    end else if (load) begin
      data <= load_data;
      ptr  <= '0;
      rack <= 1'b1;
    end else if (clr) begin
      rack <= 1'b0;
    end else if (pop && rack) begin
      ptr <= ptr + 1'b1;
      if (ptr == LAST) rack <= 1'b0;
    end
  end

  assign pop_byte = rack ? data[{ptr, 3'b000} +: 8] : 8'h00;

  assert_rack_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rack) |-> $past(load));
  assert_rack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rack) |-> ($past(clr) || ($past(pop) && $past(ptr) == LAST)));
endmodule

// File: rtl/spi_page_slave.sv
module spi_page_slave #(
  parameter int NBYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_cs_n,
  input  logic        spi_sclk,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        bk_req,
  output logic        bk_we,
  output logic [7:0]  bk_page,
  output logic [7:0]  bk_addr,
  output logic [63:0] bk_wdata,
  output logic [3:0]  bk_wbytes,
  input  logic        bk_ack,
  input  logic [63:0] bk_rdata
);
  import spi_pg_pkg::*;
  localparam int DW = 8 * NBYTES;
  localparam int CW = 4;
  localparam logic [CW-1:0] NB_C = CW'(NBYTES);

  logic       byte_done, frame_end;
  logic [7:0] rx_byte, tx_byte;
  logic [3:0] idx;
  logic [7:0] cmd_q, addr_q, page_q;
  logic [DW-1:0] wbuf;
  logic [CW-1:0] wcnt;
  logic       rack;
  logic [7:0] pop_byte;
  logic       addr_evt, rd_addr_evt, stage_pop, stage_clr, stage_load;
  logic       launch_rd, launch_wr;

  spi_pg_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk),
    .mosi(spi_mosi), .tx_byte(tx_byte), .miso(spi_miso),
    .byte_done(byte_done), .rx_byte(rx_byte), .frame_end(frame_end)
  );

  spi_pg_stage #(.NBYTES(NBYTES)) u_stage (
    .clk(clk), .rst_n(rst_n), .load(stage_load), .load_data(bk_rdata[DW-1:0]),
    .pop(stage_pop), .clr(stage_clr), .rack(rack), .pop_byte(pop_byte)
  );

  assign addr_evt    = byte_done && (idx == 4'd1);
  assign rd_addr_evt = addr_evt && (cmd_q == OP_READ);
  assign stage_pop   = rd_addr_evt && (rx_byte == ADR_DPORT);
  assign stage_clr   = rd_addr_evt && !is_local(rx_byte);
  assign stage_load  = bk_req && bk_ack && !bk_we;
  assign launch_rd   = stage_clr && !bk_req;
  assign launch_wr   = frame_end && (cmd_q == OP_WRITE) && !is_local(addr_q)
                       && (wcnt != '0) && !bk_req;

  always_comb begin
    tx_byte = 8'h00;
    if (rd_addr_evt) begin
      case (rx_byte)
        ADR_STAT:  tx_byte = stat_byte(!bk_req, rack);
        ADR_DPORT: tx_byte = pop_byte;
        ADR_PAGE:  tx_byte = page_q;
        default:   tx_byte = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= 4'd0; cmd_q <= 8'h00; addr_q <= 8'h00; page_q <= 8'h00;
      wbuf <= '0; wcnt <= '0;
    end else if (frame_end) begin
      idx <= 4'd0; cmd_q <= 8'h00; wbuf <= '0; wcnt <= '0;
    end else if (byte_done) begin
      if (idx != 4'hF) idx <= idx + 4'd1;
      if (idx == 4'd0) cmd_q <= rx_byte;
      if (idx == 4'd1) addr_q <= rx_byte;
      if (idx >= 4'd2 && cmd_q == OP_WRITE) begin
        if (addr_q == ADR_PAGE) begin
          if (idx == 4'd2) page_q <= rx_byte;
        end else if (!is_local(addr_q) && wcnt < NB_C) begin
          wbuf[{wcnt, 3'b000} +: 8] <= rx_byte;
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bk_req <= 1'b0; bk_we <= 1'b0; bk_page <= 8'h00; bk_addr <= 8'h00;
      bk_wdata <= '0; bk_wbytes <= '0;
    end else if (bk_req) begin
      if (bk_ack) bk_req <= 1'b0;
    end else if (launch_rd) begin
      bk_req <= 1'b1; bk_we <= 1'b0; bk_page <= page_q; bk_addr <= rx_byte;
      bk_wbytes <= '0;
    end else if (launch_wr) begin
      bk_req <= 1'b1; bk_we <= 1'b1; bk_page <= page_q; bk_addr <= addr_q;
      bk_wdata <= 64'(wbuf); bk_wbytes <= wcnt;
    end
  end

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_req && !bk_ack) |=> (bk_req && $stable(bk_addr) && $stable(bk_we) && $stable(bk_page)));
  assert_local_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_evt && is_local(rx_byte)) |=> !$rose(bk_req));
  assert_wcnt_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= NB_C);
  assert_cmd_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bk_req) |-> ($past(cmd_q) == OP_READ || $past(cmd_q) == OP_WRITE));
endmodule

// File: tb/spi_page_slave_test.sv
module spi_page_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso, bk_req, bk_we, bk_ack;
  logic [7:0] bk_page, bk_addr;
  logic [63:0] bk_wdata, bk_rdata;
  logic [3:0] bk_wbytes;

  always #10 clk = ~clk;

  spi_page_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .bk_req(bk_req), .bk_we(bk_we), .bk_page(bk_page),
    .bk_addr(bk_addr), .bk_wdata(bk_wdata), .bk_wbytes(bk_wbytes),
    .bk_ack(bk_ack), .bk_rdata(bk_rdata)
  );

  int n_tests = 0, n_fail = 0;
  int req_cnt = 0, wait_c = 0, ack_delay = 3;
  logic last_we; logic [7:0] last_page, last_addr;
  logic [63:0] last_wdata; logic [3:0] last_wbytes;
  logic [7:0] tb_tx [16];
  logic [7:0] tb_rx [16];

  // back-side register model: byte i = page ^ (addr + 37*i)
  function automatic logic [63:0] model(input logic [7:0] pg, input logic [7:0] ad);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = pg ^ (ad + 8'(i * 37));
    return v;
  endfunction

  always @(negedge clk) begin
    bk_ack = 1'b0;
    if (rst_n && bk_req) begin
      wait_c++;
      if (wait_c >= ack_delay) begin
        wait_c = 0; bk_ack = 1'b1; req_cnt++;
        last_we = bk_we; last_page = bk_page; last_addr = bk_addr;
        last_wdata = bk_wdata; last_wbytes = bk_wbytes;
        bk_rdata = model(bk_page, bk_addr);
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int n);
    cs_n = 1'b0; wait_clk(5);
    for (int b = 0; b < n; b++) begin
      for (int k = 7; k >= 0; k--) begin
        mosi = tb_tx[b][k]; wait_clk(5);
        tb_rx[b][k] = miso; sclk = 1'b1; wait_clk(5);
        sclk = 1'b0;
      end
    end
    wait_clk(5); cs_n = 1'b1; wait_clk(12);
  endtask

  task automatic f3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    tb_tx[0] = a; tb_tx[1] = b; tb_tx[2] = c; frame(3);
  endtask

  function automatic logic [7:0] status(input bit idle, input bit rack);
    return {idle, 1'b0, rack, 5'b0};
  endfunction

  // {page, addr} vectors for staged reads
  localparam logic [15:0] VEC [4] = '{16'h0012, 16'h0380, 16'h7F01, 16'hA5EF};

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] exp;
    int rc;
    bk_rdata = '0; bk_ack = 1'b0;
    wait_clk(5); rst_n = 1'b1; wait_clk(3);
    // R10 reset state
    check(bk_req == 1'b0, "R10 req", bk_req, 0);
    check(miso == 1'b0, "R10 miso", miso, 0);
    f3(8'h60, 8'hFF, 8'h00);
    check(tb_rx[2] == 8'h00, "R10 page", tb_rx[2], 0);
    f3(8'h60, 8'hFE, 8'h00);
    check(tb_rx[2] == status(1, 0), "R10 R5 status", tb_rx[2], status(1, 0));

    foreach (VEC[v]) begin
      f3(8'h61, 8'hFF, VEC[v][15:8]);                     // R3 set page
      rc = req_cnt;
      tb_tx[0] = 8'h60; tb_tx[1] = VEC[v][7:0]; frame(2);  // R4 launch read
      check(req_cnt == rc + 1 && !last_we && last_page == VEC[v][15:8] && last_addr == VEC[v][7:0],
            "R4 R3 read request", {last_page, last_addr}, VEC[v]);
      f3(8'h60, 8'hFE, 8'h00);
      check(tb_rx[2] == status(1, 1), "R5 R6 rack set", tb_rx[2], status(1, 1));
      exp = model(VEC[v][15:8], VEC[v][7:0]);
      for (int i = 0; i < 8; i++) begin
        f3(8'h60, 8'hF0, 8'h00);
        check(tb_rx[2] == exp[i*8 +: 8], "R6 data byte", tb_rx[2], exp[i*8 +: 8]);
      end
      f3(8'h60, 8'hFE, 8'h00);
      check(tb_rx[2] == status(1, 0), "R7 rack clear after last", tb_rx[2], status(1, 0));
      f3(8'h60, 8'hF0, 8'h00);
      check(tb_rx[2] == 8'h00, "R7 empty port", tb_rx[2], 0);
      check(req_cnt == rc + 1, "R9 local reads no request", req_cnt, rc + 1);
    end

    // R8 short write, LSB first
    f3(8'h61, 8'hFF, 8'h42);
    tb_tx[0] = 8'h61; tb_tx[1] = 8'h33; tb_tx[2] = 8'hA1; tb_tx[3] = 8'hB2; tb_tx[4] = 8'hC3;
    frame(5);
    check(last_we && last_wbytes == 4'd3 && last_wdata == 64'h0000_0000_00C3_B2A1 && last_page == 8'h42 && last_addr == 8'h33,
          "R8 R3 write", last_wdata, 64'h00C3B2A1);
    // R8 overlong write truncated to 8
    tb_tx[0] = 8'h61; tb_tx[1] = 8'h44;
    for (int i = 0; i < 10; i++) tb_tx[2 + i] = 8'(8'h10 + i);
    frame(12);
    check(last_wbytes == 4'd8 && last_wdata == 64'h1716_1514_1312_1110,
          "R8 truncate", last_wdata, 64'h1716151413121110);

    // R2 unknown command ignored
    rc = req_cnt;
    f3(8'h55, 8'hFF, 8'h99);
    f3(8'h60, 8'hFF, 8'h00);
    check(tb_rx[2] == 8'h42 && req_cnt == rc, "R2 unknown cmd", tb_rx[2], 8'h42);

    // R9 writes to local addresses ignored
    f3(8'h61, 8'hFE, 8'hFF);
    f3(8'h61, 8'hF0, 8'h77);
    f3(8'h60, 8'hFE, 8'h00);
    check(tb_rx[2] == status(1, 0) && req_cnt == rc, "R9 local write", tb_rx[2], status(1, 0));

    // R7 new read command clears rack; R5 idle bit during pending fetch
    tb_tx[0] = 8'h60; tb_tx[1] = 8'h20; frame(2);
    f3(8'h60, 8'hF0, 8'h00);
    exp = model(8'h42, 8'h20);
    check(tb_rx[2] == exp[7:0], "R6 first byte", tb_rx[2], exp[7:0]);
    ack_delay = 2000;
    tb_tx[0] = 8'h60; tb_tx[1] = 8'h21; frame(2);
    f3(8'h60, 8'hFE, 8'h00);
    check(tb_rx[2] == status(0, 0), "R7 R5 cleared by new read", tb_rx[2], status(0, 0));
    wait (bk_ack); ack_delay = 3; wait_clk(4);
    f3(8'h60, 8'hFE, 8'h00);
    check(tb_rx[2] == status(1, 1), "R5 restaged", tb_rx[2], status(1, 1));
    exp = model(8'h42, 8'h21);
    f3(8'h60, 8'hF0, 8'h00);
    check(tb_rx[2] == exp[7:0], "R6 new data first", tb_rx[2], exp[7:0]);

    // R1 chip select abort resets byte counter
    cs_n = 1'b0; wait_clk(5);
    for (int k = 7; k >= 3; k--) begin
      mosi = 1'b1; wait_clk(5); sclk = 1'b1; wait_clk(5); sclk = 1'b0;
    end
    wait_clk(5); cs_n = 1'b1; wait_clk(12);
    check(miso == 1'b0, "R1 miso idle", miso, 0);
    f3(8'h60, 8'hFF, 8'h00);
    check(tb_rx[2] == 8'h42, "R1 realigned frame", tb_rx[2], 8'h42);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule